// File: doc/BRIEF.md
# Power sequence engine

This block runs a stored power-up or power-down script without software involvement. After a start pulse it fetches packed command entries one by one from a sequence memory port, starting at address zero. For each entry it decides whether the entry applies to the present silicon. It makes that decision by comparing the entry's revision, fabrication and host-interface masks with three one-hot configuration inputs. An entry that applies is carried out on a simple request/acknowledge register bus.

Five operations exist. A masked read latches a result. A masked read-modify-write changes only the selected bits. A masked poll repeats until a match or until its attempt budget runs out. A delay counts clock cycles, in microseconds or milliseconds. An end command stops the script. A poll that runs out of attempts aborts the script with a sticky error. The block reports busy, done and error levels, and it exposes the last masked read result.

Top module: `pwr_seq_engine`

## Requirements
- R1: Entries are 56 bits wide, packed as offset[55:40], command[39:36], base[35:32], mask[31:24], value[23:16], revision mask[15:8], fabrication mask[7:4] and interface mask[3:0]. They are fetched in order from address 0. `seq_data_i` is taken one cycle after `seq_rd_o`, and each entry costs three cycles of fetch and decode before it runs.
- R2: An entry runs only if all three of these are nonzero: its revision mask ANDed with `rev_sel_i`, its fabrication mask ANDed with `fab_sel_i`, and its interface mask ANDed with `host_sel_i`. Any other entry is skipped in its three decode cycles, with no bus access.
- R3: Command 0 (read) performs one bus read, and `rd_data_o` becomes the read data ANDed with the mask. That value holds until the next read command or the next accepted start, and an accepted start clears it to 0.
- R4: Command 1 (write) performs a bus read and then a bus write of (read data AND NOT mask) OR (value AND mask).
- R5: Command 2 (poll) repeats bus reads until (read data AND mask) equals (value AND mask), then proceeds to the next entry.
- R6: If POLL_LIMIT poll reads in a row mismatch, `err_o` and `done_o` go high and no further entry is fetched.
- R7: Command 3 (delay) with value bit 0 equal to 0 adds offset × CYC_PER_US cycles to the entry.
- R8: Command 3 with value bit 0 equal to 1 adds offset × CYC_PER_US × US_PER_MS cycles.
- R9: A delay with offset 0 adds no cycles beyond the decode cycles.
- R10: Command 4 (end) takes effect whatever the masks are. It raises `done_o` with `err_o` low and drops `busy_o`. Done and error hold until a start is accepted in the idle or done state; that start clears them and raises `busy_o`.
- R11: Every bus access presents the entry's offset on `bus_addr_o` and its base field on `bus_base_o`.
- R12: Command codes 5 to 15 are skipped in their decode cycles with no bus access.
- R13: After reset `busy_o`, `done_o`, `err_o`, `bus_req_o` and `rd_data_o` are all 0.
- R14: `bus_req_o` is held with address, base, direction and write data stable until a cycle with `bus_ack_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when not busy |
| rev_sel_i | input | 8 | One-hot chip revision |
| fab_sel_i | input | 4 | One-hot fabrication variant |
| host_sel_i | input | 4 | One-hot host interface |
| seq_rd_o | output | 1 | Sequence memory read strobe |
| seq_addr_o | output | ADDR_W | Sequence memory address |
| seq_data_i | input | 56 | Entry returned one cycle after the strobe |
| bus_req_o | output | 1 | Register bus request |
| bus_we_o | output | 1 | Register bus write when high |
| bus_base_o | output | 4 | Register space selector |
| bus_addr_o | output | 16 | Register offset |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Register bus acknowledge |
| bus_rdata_i | input | 8 | Read data, valid with the acknowledge |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | Script finished or aborted |
| err_o | output | 1 | Sticky poll timeout |
| rd_data_o | output | 8 | Last masked read result |

## Verification
The bench builds the engine with CYC_PER_US = 3, US_PER_MS = 4, POLL_LIMIT = 5 and ADDR_W = 4. With these values a millisecond delay lasts 12 cycles, so delay lengths can be measured exactly against a bare end-of-script run. A poll timeout is reached after five reads instead of ten thousand. The register model makes a polled location change after a chosen number of reads, which exercises both a poll that succeeds and a poll that times out.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    OP_READ  = 4'd0,
    OP_WRITE = 4'd1,
    OP_POLL  = 4'd2,
    OP_WAIT  = 4'd3,
    OP_END   = 4'd4
  } op_e;

  typedef struct packed {
    logic [15:0] offset;
    logic [3:0]  cmd;
    logic [3:0]  base;
    logic [7:0]  mask;
    logic [7:0]  value;
    logic [7:0]  rev;
    logic [3:0]  fab;
    logic [3:0]  intf;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_EXEC,
    ST_RD,
    ST_WR,
    ST_DLY,
    ST_DONE
  } state_e;

endpackage

// File: rtl/pwr_seq_match.sv
module pwr_seq_match
  import pwr_seq_pkg::*;
(
  input  entry_t     ent_i,
  input  logic [7:0] rev_sel_i,
  input  logic [3:0] fab_sel_i,
  input  logic [3:0] host_sel_i,
  output logic       hit_o,
  output logic       known_o,
  output logic       is_end_o
);
  logic rev_ok, fab_ok, host_ok;

  assign rev_ok   = |(ent_i.rev & rev_sel_i);
  assign fab_ok   = |(ent_i.fab & fab_sel_i);
  assign host_ok  = |(ent_i.intf & host_sel_i);
  assign hit_o    = rev_ok && fab_ok && host_ok;
  assign known_o  = (ent_i.cmd <= OP_END);
  assign is_end_o = (ent_i.cmd == OP_END);
endmodule

// File: rtl/pwr_seq_datapath.sv
module pwr_seq_datapath #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] value_i,
  output logic [DW-1:0] masked_o,
  output logic [DW-1:0] merged_o,
  output logic          match_o
);
  assign masked_o = rdata_i & mask_i;
  assign merged_o = (rdata_i & ~mask_i) | (value_i & mask_i);
  assign match_o  = (masked_o == (value_i & mask_i));
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int AMT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic             unit_ms_i,
  input  logic             run_i,
  output logic             expire_o
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int SW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(US_PER_MS - 1);

  logic [PW-1:0]    pre_q;
  logic [SW-1:0]    sub_q;
  logic [AMT_W-1:0] amt_q;
  logic             ms_q;
  logic             pre_wrap, sub_wrap;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign sub_wrap = !ms_q || (sub_q == SUB_LAST);
  assign expire_o = run_i && pre_wrap && sub_wrap && (amt_q == AMT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sub_q <= '0;
      amt_q <= '0;
      ms_q  <= 1'b0;
    end else if (load_i) begin
      pre_q <= '0;
      sub_q <= '0;
      amt_q <= amount_i;
      ms_q  <= unit_ms_i;
    end else if (run_i) begin
      if (pre_wrap) begin
        pre_q <= '0;
        if (sub_wrap) begin
          sub_q <= '0;
          amt_q <= amt_q - AMT_W'(1);
        end else begin
          sub_q <= sub_q + SW'(1);
        end
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
  import pwr_seq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int POLL_LIMIT = 10000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [7:0]                    rev_sel_i,
  input  logic [3:0]                    fab_sel_i,
  input  logic [3:0]                    host_sel_i,
  output logic                          seq_rd_o,
  output logic [ADDR_W-1:0]             seq_addr_o,
  input  logic [pwr_seq_pkg::ENTRY_W-1:0] seq_data_i,
  output logic                          bus_req_o,
  output logic                          bus_we_o,
  output logic [3:0]                    bus_base_o,
  output logic [15:0]                   bus_addr_o,
  output logic [7:0]                    bus_wdata_o,
  input  logic                          bus_ack_i,
  input  logic [7:0]                    bus_rdata_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic [7:0]                    rd_data_o
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_LIMIT - 1);

  state_e          state_q;
  entry_t          ent_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [PCW-1:0]  poll_cnt_q;
  logic [7:0]      wdata_q, rd_q;
  logic            err_q;

  logic            hit, known, is_end;
  logic [7:0]      masked, merged;
  logic            poll_match;
  logic            dly_expire;

  pwr_seq_match u_match (
    .ent_i      (ent_q),
    .rev_sel_i  (rev_sel_i),
    .fab_sel_i  (fab_sel_i),
    .host_sel_i (host_sel_i),
    .hit_o      (hit),
    .known_o    (known),
    .is_end_o   (is_end)
  );

  pwr_seq_datapath #(.DW(8)) u_dp (
    .rdata_i  (bus_rdata_i),
    .mask_i   (ent_q.mask),
    .value_i  (ent_q.value),
    .masked_o (masked),
    .merged_o (merged),
    .match_o  (poll_match)
  );

  pwr_seq_timer #(
    .CYC_PER_US (CYC_PER_US),
    .US_PER_MS  (US_PER_MS),
    .AMT_W      (16)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_q == ST_EXEC),
    .amount_i  (ent_q.offset),
    .unit_ms_i (ent_q.value[0]),
    .run_i     (state_q == ST_DLY),
    .expire_o  (dly_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ent_q      <= '0;
      ptr_q      <= '0;
      poll_cnt_q <= '0;
      wdata_q    <= '0;
      rd_q       <= '0;
      err_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_FETCH;
            ptr_q   <= '0;
            err_q   <= 1'b0;
            rd_q    <= '0;
          end
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          ent_q   <= entry_t'(seq_data_i);
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          poll_cnt_q <= '0;
          if (is_end) begin
            state_q <= ST_DONE;
          end else if (!known || !hit) begin
            ptr_q   <= ptr_q + ADDR_W'(1);
            state_q <= ST_FETCH;
          end else if (ent_q.cmd == OP_WAIT) begin
            if (ent_q.offset == '0) begin
              ptr_q   <= ptr_q + ADDR_W'(1);
              state_q <= ST_FETCH;
            end else begin
              state_q <= ST_DLY;
            end
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (bus_ack_i) begin
            if (ent_q.cmd == OP_READ) begin
              rd_q    <= masked;
              ptr_q   <= ptr_q + ADDR_W'(1);
              state_q <= ST_FETCH;
            end else if (ent_q.cmd == OP_WRITE) begin
              wdata_q <= merged;
              state_q <= ST_WR;
            end else if (poll_match) begin
              ptr_q   <= ptr_q + ADDR_W'(1);
              state_q <= ST_FETCH;
            end else if (poll_cnt_q == POLL_LAST) begin
              err_q   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              poll_cnt_q <= poll_cnt_q + PCW'(1);
            end
          end
        end
        ST_WR: begin
          if (bus_ack_i) begin
            ptr_q   <= ptr_q + ADDR_W'(1);
            state_q <= ST_FETCH;
          end
        end
        ST_DLY: begin
          if (dly_expire) begin
            ptr_q   <= ptr_q + ADDR_W'(1);
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign seq_rd_o    = (state_q == ST_FETCH);
  assign seq_addr_o  = ptr_q;
  assign bus_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_we_o    = (state_q == ST_WR);
  assign bus_base_o  = ent_q.base;
  assign bus_addr_o  = ent_q.offset;
  assign bus_wdata_o = wdata_q;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = err_q;
  assign rd_data_o   = rd_q;
endmodule

// File: rtl/pwr_seq_engine_chk.sv
module pwr_seq_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        seq_rd_o,
  input logic        bus_req_o,
  input logic        bus_we_o,
  input logic [3:0]  bus_base_o,
  input logic [15:0] bus_addr_o,
  input logic [7:0]  bus_wdata_o,
  input logic        bus_ack_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [7:0]  rd_data_o
);
  assert_req_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_base_o)
                                && $stable(bus_we_o) && $stable(bus_wdata_o));

  assert_err_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !busy_o);

  assert_quiet_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o && !seq_rd_o);

  assert_start_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o && !err_o);

  assert_rd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && !busy_o) && !(bus_req_o && bus_ack_i && !bus_we_o) |=> $stable(rd_data_o));

  assert_fetch_no_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_rd_o |-> !bus_req_o);
endmodule

bind pwr_seq_engine pwr_seq_engine_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .seq_rd_o    (seq_rd_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_base_o  (bus_base_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/pwr_seq_engine_test.sv
module pwr_seq_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 3;
  localparam int UPM = 4;
  localparam int PLIM = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  rev_sel = 8'h04;
  logic [3:0]  fab_sel = 4'h1;
  logic [3:0]  host_sel = 4'h2;
  logic        seq_rd;
  logic [3:0]  seq_addr;
  logic [55:0] seq_data = '0;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [3:0]  bus_base;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata = '0;
  logic        busy, done, err;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;

  typedef struct { bit we; logic [3:0] base; logic [15:0] addr; logic [7:0] wdata; } xact_t;
  xact_t exp_q[$];

  logic [55:0] mem [16];
  logic [7:0]  regs [16];
  int          poll_addr = -1;
  int          poll_after = 0;
  logic [7:0]  poll_val = '0;
  int          rd_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_engine #(
    .ADDR_W(4), .CYC_PER_US(CPU), .US_PER_MS(UPM), .POLL_LIMIT(PLIM)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rev_sel_i(rev_sel), .fab_sel_i(fab_sel), .host_sel_i(host_sel),
    .seq_rd_o(seq_rd), .seq_addr_o(seq_addr), .seq_data_i(seq_data),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_base_o(bus_base),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack),
    .bus_rdata_i(bus_rdata), .busy_o(busy), .done_o(done), .err_o(err),
    .rd_data_o(rd_data)
  );

  // sequence memory, one cycle read latency
  always @(posedge clk) if (seq_rd) seq_data <= mem[seq_addr];

  // register model: acknowledge one cycle after each request
  always @(posedge clk) begin
    if (start) rd_cnt <= 0;
    if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) regs[bus_addr[3:0]] <= bus_wdata;
      else if (int'(bus_addr[3:0]) == poll_addr) begin
        bus_rdata <= (rd_cnt >= poll_after) ? poll_val : regs[bus_addr[3:0]];
        rd_cnt <= rd_cnt + 1;
      end else bus_rdata <= regs[bus_addr[3:0]];
    end else bus_ack <= 1'b0;
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_req && bus_ack) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 actual=unexpected access addr %0h expected=none", bus_addr);
      end else begin
        xact_t e;
        e = exp_q.pop_front();
        if (e.we !== bus_we || e.base !== bus_base || e.addr !== bus_addr ||
            (e.we && e.wdata !== bus_wdata)) begin
          errors++;
          $display("FAIL R11 actual=%0b/%0h/%0h/%0h expected=%0b/%0h/%0h/%0h",
                   bus_we, bus_base, bus_addr, bus_wdata, e.we, e.base, e.addr, e.wdata);
        end
      end
    end
  end

  function automatic logic [55:0] mk(input logic [15:0] off, input logic [3:0] op,
      input logic [3:0] base, input logic [7:0] msk, input logic [7:0] val,
      input logic [7:0] rev, input logic [3:0] fab, input logic [3:0] hs);
    return {off, op, base, msk, val, rev, fab, hs};
  endfunction

  function automatic logic [55:0] mk_all(input logic [15:0] off, input logic [3:0] op,
      input logic [3:0] base, input logic [7:0] msk, input logic [7:0] val);
    return mk(off, op, base, msk, val, 8'hFF, 4'hF, 4'hF);
  endfunction

  task automatic push(input bit we, input logic [3:0] base, input logic [15:0] addr,
                      input logic [7:0] wd);
    xact_t x;
    x.we = we; x.base = base; x.addr = addr; x.wdata = wd;
    exp_q.push_back(x);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) mem[i] = mk(16'h0, 4'd4, 4'h0, 8'h0, 8'h0, 8'h0, 4'h0, 4'h0);
  endtask

  task automatic run(output int cyc);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 3000) check("R10 timeout", 0, 1);
    check("R2 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c_end, c;
    for (int i = 0; i < 16; i++) regs[i] <= 8'h00;
    clear_mem();
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 busy", busy, 0);
    check("R13 done", done, 0);
    check("R13 err", err, 0);
    check("R13 req", bus_req, 0);
    check("R13 rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 bare end
    run(c_end);
    check("R10 done", done, 1);
    check("R10 err", err, 0);
    check("R10 busy", busy, 0);

    // R3 read, R4 write, R11 base
    regs[3] <= 8'hA5; regs[6] <= 8'h3C;
    clear_mem();
    mem[0] = mk_all(16'd3, 4'd0, 4'd1, 8'h0F, 8'h00);
    mem[1] = mk_all(16'd6, 4'd1, 4'd2, 8'hF0, 8'h9A);
    push(0, 4'd1, 16'd3, 8'h00);
    push(0, 4'd2, 16'd6, 8'h00);
    push(1, 4'd2, 16'd6, 8'h9C);
    run(c);
    check("R3 masked read", rd_data, 8'h05);
    check("R4 merged value stored", regs[6], 8'h9C);
    @(negedge clk);
    check("R3 held while done", rd_data, 8'h05);

    // R3 read back merged value on base 3
    clear_mem();
    mem[0] = mk_all(16'd6, 4'd0, 4'd3, 8'hFF, 8'h00);
    push(0, 4'd3, 16'd6, 8'h00);
    run(c);
    check("R3 read after rmw", rd_data, 8'h9C);

    // R3 start clears result
    clear_mem();
    run(c);
    check("R3 cleared by start", rd_data, 0);

    // R2 filtering, R12 unknown code
    regs[2] <= 8'h77;
    clear_mem();
    mem[0] = mk(16'd2, 4'd0, 4'd0, 8'hFF, 8'h00, 8'h02, 4'hF, 4'hF);
    mem[1] = mk(16'd2, 4'd0, 4'd0, 8'hFF, 8'h00, 8'hFF, 4'h2, 4'hF);
    mem[2] = mk(16'd2, 4'd0, 4'd0, 8'hFF, 8'h00, 8'hFF, 4'hF, 4'h1);
    mem[3] = mk_all(16'd2, 4'd7, 4'd0, 8'hFF, 8'h00);
    mem[4] = mk(16'd2, 4'd0, 4'd0, 8'hF0, 8'h00, 8'h04, 4'h1, 4'h2);
    push(0, 4'd0, 16'd2, 8'h00);
    run(c);
    check("R2 only matching entry read", rd_data, 8'h70);
    clear_mem();
    mem[0] = mk(16'd2, 4'd0, 4'd0, 8'hFF, 8'h00, 8'h01, 4'hF, 4'hF);
    run(c);
    check("R2 skip costs three cycles", c, c_end + 3);
    clear_mem();
    mem[0] = mk_all(16'd2, 4'd12, 4'd0, 8'hFF, 8'h00);
    run(c);
    check("R12 unknown code skipped", c, c_end + 3);

    // R5 poll success after two mismatches
    regs[9] <= 8'h00; poll_addr = 9; poll_after = 2; poll_val = 8'h83;
    clear_mem();
    mem[0] = mk_all(16'd9, 4'd2, 4'd1, 8'h81, 8'h81);
    mem[1] = mk_all(16'd3, 4'd0, 4'd0, 8'hFF, 8'h00);
    repeat (3) push(0, 4'd1, 16'd9, 8'h00);
    push(0, 4'd0, 16'd3, 8'h00);
    run(c);
    check("R5 poll completes", err, 0);
    check("R5 next entry runs", rd_data, 8'hA5);

    // R6 poll timeout aborts
    poll_addr = -1;
    regs[10] <= 8'h00;
    clear_mem();
    mem[0] = mk_all(16'd10, 4'd2, 4'd0, 8'h01, 8'h01);
    mem[1] = mk_all(16'd3, 4'd0, 4'd0, 8'hFF, 8'h00);
    repeat (PLIM) push(0, 4'd0, 16'd10, 8'h00);
    run(c);
    check("R6 error set", err, 1);
    check("R6 done set", done, 1);
    check("R6 following entry not run", rd_data, 0);
    repeat (4) @(negedge clk);
    check("R6 error sticky", err, 1);
    clear_mem();
    run(c);
    check("R10 start clears error", err, 0);

    // R9, R7, R8 delays
    clear_mem();
    mem[0] = mk_all(16'd0, 4'd3, 4'd0, 8'h00, 8'h00);
    run(c);
    check("R9 zero delay", c, c_end + 3);
    mem[0] = mk_all(16'd2, 4'd3, 4'd0, 8'h00, 8'h00);
    run(c);
    check("R7 microsecond delay", c, c_end + 3 + 2 * CPU);
    mem[0] = mk_all(16'd1, 4'd3, 4'd0, 8'h00, 8'h01);
    run(c);
    check("R8 millisecond delay", c, c_end + 3 + CPU * UPM);
    mem[0] = mk_all(16'd2, 4'd3, 4'd0, 8'h00, 8'h01);
    run(c);
    check("R8 two millisecond delay", c, c_end + 3 + 2 * CPU * UPM);

    // R1 ordering: two reads in sequence, last one wins
    regs[4] <= 8'h11; regs[5] <= 8'h22;
    clear_mem();
    mem[0] = mk_all(16'd4, 4'd0, 4'd0, 8'hFF, 8'h00);
    mem[1] = mk_all(16'd5, 4'd0, 4'd0, 8'hFF, 8'h00);
    push(0, 4'd0, 16'd4, 8'h00);
    push(0, 4'd0, 16'd5, 8'h00);
    run(c);
    check("R1 entries in order", rd_data, 8'h22);
    check("R1 two reads cost", c >= c_end + 10 ? 1 : 0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule